// File: doc/BRIEF.md
# Multidrop TAP Connect Switch Controller

This block decides whether one secondary JTAG test access port is joined to a shared, multidrop primary test access port, and it gates the scan signals to match. A protocol receiver placed elsewhere decodes the addressing traffic on the primary data line. It delivers a 3-bit result code with a one-cycle valid strobe. From these codes the controller keeps a protocol status: reset, on, off or multicast. A dedicated active-low bypass pin can force a connection asynchronously, whatever the protocol status, and the active-low test reset returns the block to its disconnected reset condition.

The effective status is picked from bypass, test reset and the protocol status, in that order of priority. It sets the secondary mode-select output, the secondary data output, the primary data output, their output enables and an active-low connect indicator. In the off status the secondary mode-select line keeps the level it had at the last clock edge before the disconnect. A secondary chain can therefore be parked in a stable state. The test clock and the test reset are copied to the secondary side with no register in the path.

Top module: `tap_connect_switch`

## Requirements
- R1: While rst_ni is low and bypass_ni is high, stms_o is 1, stdo_oe_o and ptdo_oe_o are 0 and connect_no is 1. The protocol status returns to reset asynchronously.
- R2: stck_o always equals clk_i and strst_no always equals rst_ni.
- R3: While bypass_ni is low and rst_ni is high, stms_o follows ptms_i, stdo_o follows ptdi_i and ptdo_o follows stdi_i, with both enables 1 and connect_no 0. This holds whatever the protocol status. When rst_ni is released with bypass_ni still low, this status applies at once.
- R4: While bypass_ni and rst_ni are both low, stms_o is 1, both data paths pass with their enables 1, and connect_no is 0.
- R5: While bypass_ni is low, result strobes do not change the protocol status. After bypass_ni returns high, the status in force beforehand shows at the outputs.
- R6: Result code 1 (match) selects the on status, in which the outputs behave as in R3 with bypass high.
- R7: Result codes 2 (no match), 3 (hard error) and 4 (disconnect) select the off status. In off, both enables are 0 and connect_no is 1.
- R8: Result code 5 selects the reset status: stms_o is 1, both enables are 0 and connect_no is 1.
- R9: Result code 6 selects the multicast status. In multicast, stms_o follows ptms_i and stdo_o follows ptdi_i with stdo_oe_o at 1, ptdo_oe_o is 0, and connect_no is 0.
- R10: Codes 0 and 7, and any cycle with res_valid_i low, leave the protocol status unchanged.
- R11: A result strobe takes effect on the rising clk_i edge that samples it. The outputs show the new status only after that edge.
- R12: In off, stms_o holds the value it had at the last rising clk_i edge before off was entered: the sampled ptms_i when coming from a passing status, 1 when coming from reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Primary test clock |
| rst_ni | input | 1 | Primary test reset, active low, asynchronous |
| bypass_ni | input | 1 | Forced connection request, active low |
| ptms_i | input | 1 | Primary mode select |
| ptdi_i | input | 1 | Primary test data in |
| stdi_i | input | 1 | Secondary test data in |
| res_valid_i | input | 1 | One-cycle strobe for res_code_i |
| res_code_i | input | 3 | Protocol result code |
| stck_o | output | 1 | Secondary test clock |
| strst_no | output | 1 | Secondary test reset, active low |
| stms_o | output | 1 | Secondary mode select |
| stdo_o | output | 1 | Secondary test data out |
| stdo_oe_o | output | 1 | Enable for stdo_o |
| ptdo_o | output | 1 | Primary test data out |
| ptdo_oe_o | output | 1 | Enable for ptdo_o |
| connect_no | output | 1 | Connected indicator, active low |

## Verification
Bypass, test reset and the data and clock pass-throughs are combinational, so they are due in the same cycle as the input change. The bench drives on the falling edge and samples 1 ns later. A result strobe is registered once, which means its effect is due only after the next rising edge. The bench therefore checks the old status in the strobe cycle and the new status in the following cycle. The hold level is modelled in the bench at each rising edge from the mode-select value the bench expected just before that edge. This models the one-edge lag of the hold register exactly.

// File: rtl/tcs_pkg.sv
package tcs_pkg;
  localparam int unsigned RES_W = 3;

  typedef enum logic [RES_W-1:0] {
    RES_NONE    = 3'd0,
    RES_MATCH   = 3'd1,
    RES_NOMATCH = 3'd2,
    RES_HARDERR = 3'd3,
    RES_DISC    = 3'd4,
    RES_RESET   = 3'd5,
    RES_SYNC    = 3'd6,
    RES_RSVD    = 3'd7
  } res_code_e;

  typedef enum logic [2:0] {
    ST_RESET,
    ST_ON,
    ST_OFF,
    ST_MCAST,
    ST_TRST,
    ST_BYP,
    ST_BYP_TRST
  } status_e;
endpackage

// File: rtl/tcs_status_ctrl.sv
module tcs_status_ctrl
  import tcs_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bypass_ni,
  input  logic             res_valid_i,
  input  logic [RES_W-1:0] res_code_i,
  output status_e          status_o
);
  status_e proto_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      proto_q <= ST_RESET;
    end else if (bypass_ni && res_valid_i) begin
      case (res_code_e'(res_code_i))
        RES_MATCH:                      proto_q <= ST_ON;
        RES_NOMATCH, RES_HARDERR,
        RES_DISC:                       proto_q <= ST_OFF;
        RES_RESET:                      proto_q <= ST_RESET;
        RES_SYNC:                       proto_q <= ST_MCAST;
        default:                        proto_q <= proto_q;
      endcase
    end
  end

  // bypass outranks test reset, which outranks the protocol status
  always_comb begin
    if (!bypass_ni)  status_o = rst_ni ? ST_BYP : ST_BYP_TRST;
    else if (!rst_ni) status_o = ST_TRST;
    else             status_o = proto_q;
  end

  a_r5_bypass_freezes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bypass_ni |=> $stable(proto_q));
  a_r10_no_strobe_no_change: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !res_valid_i |=> $stable(proto_q));
endmodule

// File: rtl/tcs_out_mux.sv
module tcs_out_mux
  import tcs_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  status_e status_i,
  input  logic    ptms_i,
  input  logic    ptdi_i,
  input  logic    stdi_i,
  output logic    stms_o,
  output logic    stdo_o,
  output logic    stdo_oe_o,
  output logic    ptdo_o,
  output logic    ptdo_oe_o,
  output logic    connect_no
);
  logic hold_q;

  // tracks the driven level at every edge outside OFF
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 hold_q <= 1'b1;
    else if (status_i != ST_OFF) hold_q <= stms_o;
  end

  assign stdo_o = ptdi_i;
  assign ptdo_o = stdi_i;

  always_comb begin
    stms_o     = 1'b1;
    stdo_oe_o  = 1'b0;
    ptdo_oe_o  = 1'b0;
    connect_no = 1'b1;
    case (status_i)
      ST_BYP, ST_ON: begin
        stms_o = ptms_i; stdo_oe_o = 1'b1; ptdo_oe_o = 1'b1; connect_no = 1'b0;
      end
      ST_BYP_TRST: begin
        stdo_oe_o = 1'b1; ptdo_oe_o = 1'b1; connect_no = 1'b0;
      end
      ST_MCAST: begin
        stms_o = ptms_i; stdo_oe_o = 1'b1; connect_no = 1'b0;
      end
      ST_OFF:  stms_o = hold_q;
      default: ;
    endcase
  end

  a_r12_off_holds_stms: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_i == ST_OFF && $past(status_i == ST_OFF)) |-> $stable(stms_o));
endmodule

// File: rtl/tap_connect_switch.sv
module tap_connect_switch
  import tcs_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bypass_ni,
  input  logic             ptms_i,
  input  logic             ptdi_i,
  input  logic             stdi_i,
  input  logic             res_valid_i,
  input  logic [RES_W-1:0] res_code_i,
  output logic             stck_o,
  output logic             strst_no,
  output logic             stms_o,
  output logic             stdo_o,
  output logic             stdo_oe_o,
  output logic             ptdo_o,
  output logic             ptdo_oe_o,
  output logic             connect_no
);
  status_e status;

  assign stck_o   = clk_i;
  assign strst_no = rst_ni;

  tcs_status_ctrl i_status (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .bypass_ni   (bypass_ni),
    .res_valid_i (res_valid_i),
    .res_code_i  (res_code_i),
    .status_o    (status)
  );

  tcs_out_mux i_out (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .status_i   (status),
    .ptms_i     (ptms_i),
    .ptdi_i     (ptdi_i),
    .stdi_i     (stdi_i),
    .stms_o     (stms_o),
    .stdo_o     (stdo_o),
    .stdo_oe_o  (stdo_oe_o),
    .ptdo_o     (ptdo_o),
    .ptdo_oe_o  (ptdo_oe_o),
    .connect_no (connect_no)
  );

  a_r4_trst_bypass_tms_high: assert property (@(posedge clk_i)
    (!bypass_ni && !rst_ni) |-> (stms_o && !connect_no && ptdo_oe_o));
  a_r3_bypass_connects: assert property (@(posedge clk_i)
    !bypass_ni |-> (!connect_no && stdo_oe_o && ptdo_oe_o));
  a_r1_idle_floats: assert property (@(posedge clk_i)
    connect_no |-> (!stdo_oe_o && !ptdo_oe_o));
  a_r9_mcast_only_floats_ptdo: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!connect_no && !ptdo_oe_o) |-> (bypass_ni && stdo_oe_o));
endmodule

// File: tb/test_tap_connect_switch.sv
module test_tap_connect_switch;
  import tcs_pkg::*;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n = 1'b0, byp_n = 1'b1, tms = 1'b1, tdi = 1'b1, sdi = 1'b1, vld = 1'b0;
  logic [2:0] code = 3'd0;
  logic stck, strst_n, stms, stdo, stdo_oe, ptdo, ptdo_oe, con_n;

  tap_connect_switch i_tap_connect_switch (
    .clk_i(clk), .rst_ni(rst_n), .bypass_ni(byp_n), .ptms_i(tms), .ptdi_i(tdi),
    .stdi_i(sdi), .res_valid_i(vld), .res_code_i(code), .stck_o(stck),
    .strst_no(strst_n), .stms_o(stms), .stdo_o(stdo), .stdo_oe_o(stdo_oe),
    .ptdo_o(ptdo), .ptdo_oe_o(ptdo_oe), .connect_no(con_n)
  );

  int n_chk = 0, n_fail = 0;
  status_e m_st = ST_RESET;
  logic m_hold = 1'b1;
  status_e e_st;
  logic e_stms, e_sdoe, e_pdoe, e_con;

  task automatic chk(input string tag, input string what, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %b expected %b", tag, what, act, exp);
    end
  endtask

  task automatic expect_now(output string tag);
    if (!byp_n)      e_st = rst_n ? ST_BYP : ST_BYP_TRST;
    else if (!rst_n) e_st = ST_TRST;
    else             e_st = m_st;
    e_stms = 1'b1; e_sdoe = 1'b0; e_pdoe = 1'b0; e_con = 1'b1;
    case (e_st)
      ST_BYP:      begin e_stms = tms; e_sdoe = 1; e_pdoe = 1; e_con = 0; tag = "R3"; end
      ST_ON:       begin e_stms = tms; e_sdoe = 1; e_pdoe = 1; e_con = 0; tag = "R6"; end
      ST_BYP_TRST: begin e_sdoe = 1; e_pdoe = 1; e_con = 0; tag = "R4"; end
      ST_MCAST:    begin e_stms = tms; e_sdoe = 1; e_con = 0; tag = "R9"; end
      ST_OFF:      begin e_stms = m_hold; tag = "R7"; end
      ST_RESET:    tag = "R8";
      default:     tag = "R1";
    endcase
  endtask

  task automatic cyc(input logic b, input logic r, input logic ms, input logic di,
                     input logic si, input logic v, input logic [2:0] c, input string ctx);
    string tag;
    @(negedge clk);
    byp_n = b; rst_n = r; tms = ms; tdi = di; sdi = si; vld = v; code = c;
    if (!r) begin m_st = ST_RESET; m_hold = 1'b1; end
    #1;
    expect_now(tag);
    tag = {tag, ctx};
    chk("R2", "stck", stck, 1'b0);
    chk("R2", "strst_n", strst_n, r);
    chk((e_st == ST_OFF) ? {"R12", ctx} : tag, "stms", stms, e_stms);
    chk(tag, "stdo_oe", stdo_oe, e_sdoe);
    chk(tag, "ptdo_oe", ptdo_oe, e_pdoe);
    chk(tag, "connect_n", con_n, e_con);
    if (e_sdoe) chk(tag, "stdo", stdo, di);
    if (e_pdoe) chk(tag, "ptdo", ptdo, si);
    @(posedge clk);
    if (e_st != ST_OFF) m_hold = e_stms;
    if (r && b && v) begin
      case (c)
        3'd1:             m_st = ST_ON;
        3'd2, 3'd3, 3'd4: m_st = ST_OFF;
        3'd5:             m_st = ST_RESET;
        3'd6:             m_st = ST_MCAST;
        default:          ;
      endcase
    end
    #1 chk("R2", "stck high", stck, 1'b1);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #(200000 * 4);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    // R1 reset state
    cyc(1, 0, 0, 0, 1, 0, 0, " reset");
    cyc(1, 0, 1, 1, 0, 1, 1, " reset ignores strobe");
    cyc(1, 1, 0, 1, 0, 0, 0, " R8 after release");
    // R11: match strobe, old status still visible this cycle
    cyc(1, 1, 0, 1, 0, 1, 1, " R11 strobe cycle");
    cyc(1, 1, 1, 0, 1, 0, 0, " R11 after edge");
    cyc(1, 1, 0, 1, 0, 0, 0, " on pass");
    // R12: off from on, hold the sampled tms (0)
    cyc(1, 1, 0, 1, 1, 1, 2, " nomatch");
    cyc(1, 1, 1, 0, 1, 0, 0, " R12 hold 0");
    cyc(1, 1, 1, 1, 0, 0, 0, " R12 hold 0 again");
    // R10 codes 0, 7 and missing strobe
    cyc(1, 1, 1, 1, 1, 1, 0, " R10 code0");
    cyc(1, 1, 1, 1, 1, 1, 7, " R10 code7");
    cyc(1, 1, 1, 1, 1, 0, 1, " R10 no strobe");
    cyc(1, 1, 0, 0, 0, 0, 0, " R10 still off");
    // R5 strobe while bypass low is ignored
    cyc(0, 1, 1, 0, 1, 1, 1, " R5 bypass strobe");
    cyc(0, 1, 0, 1, 0, 1, 6, " R5 bypass strobe2");
    cyc(1, 1, 1, 1, 1, 0, 0, " R5 back to off");
    // R4 then R3 immediate resume
    cyc(0, 0, 0, 1, 0, 0, 0, " R4 byp+trst");
    cyc(0, 1, 0, 0, 1, 0, 0, " R3 resume");
    cyc(1, 1, 1, 1, 1, 1, 6, " sync from reset");
    cyc(1, 1, 1, 0, 1, 0, 0, " R9 mcast");
    cyc(1, 1, 1, 1, 0, 1, 3, " harderr");
    cyc(1, 1, 0, 1, 0, 0, 0, " R12 hold 1");
    cyc(1, 1, 1, 0, 0, 1, 1, " rematch");
    cyc(1, 1, 1, 0, 1, 1, 4, " disconnect");
    cyc(1, 1, 0, 0, 1, 1, 5, " R12 off then reset code");
    cyc(1, 1, 0, 1, 1, 1, 2, " R8 then off");
    cyc(1, 1, 0, 1, 1, 0, 0, " R12 hold from reset");
    for (int i = 0; i < 3000; i++) begin
      cyc(($urandom % 8) != 0, ($urandom % 32) != 0, 1'($urandom), 1'($urandom),
          1'($urandom), ($urandom % 4) == 0, 3'($urandom), " rnd");
    end
    finish_run();
  end
endmodule